// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the 64-bit system time at the moment a selected event frame starts to pass the timestamp point. It has two channels. The receive channel qualifies frames through a small message-class filter. The transmit channel captures whenever the transmit side asks for a stamp. Each channel keeps one captured value and a valid flag. The channel is locked until software reads the upper half of the value or pulses a clear strobe. Until then, further qualifying frames are ignored.

A second receive mode adds the timestamp to the packet itself. A byte stream passes through the block with one cycle of latency. When this mode is active, every packet leaves with eight extra bytes after its last byte. Those bytes hold the time sampled on the packet's first beat. The receive register channel stops capturing while this mode is on. Upstream logic supplies a per-frame indication of the message version, a message code and the frame's EtherType. The block does no frame parsing of its own.

Top module: `ts_capture_latch`

## Requirements
- R1: The receive filter `cfg_filter` selects the qualifying class. 0 matches nothing. 1 matches frames with `rx_is_v1`=1 and `rx_msg_code`=0. 2 matches frames with `rx_is_v1`=1 and `rx_msg_code`=1. 3 matches frames whose `rx_ethertype` equals `cfg_ethertype` and whose `rx_msg_code` is below 4. 4 matches every frame. Codes 5 to 7 match nothing.
- R2: A channel captures `time_i` as it is on the cycle its frame-start strobe is high and the frame qualifies. The valid flag of that channel is set from the next clock edge.
- R3: While a channel is valid, later qualifying frames leave the stored value unchanged.
- R4: A read of a channel's high word returns the upper 32 bits of the stored value. The same read clears that channel's valid flag, so a new capture can follow. A read of the low word does not release the channel.
- R5: `sw_clr[0]` releases the receive channel and `sw_clr[1]` releases the transmit channel. Each strobe acts only on its own channel.
- R6: The transmit channel captures on `tx_sof` together with `tx_ts_req`, independently of the receive filter.
- R7: Read data is registered and appears one cycle after `rd_en`. The address map is as follows. Address 0 is the status word: bit 0 is the receive valid flag, bit 1 is the transmit valid flag, and all other bits are 0. Address 1 is the receive low word and 2 the receive high word. Address 3 is the transmit low word and 4 the transmit high word. Addresses 5 to 7 read as 0.
- R8: Append mode is active when `cfg_append_en`=1 and `cfg_filter` is not 0. In this mode each packet is followed by 8 trailer bytes, least significant byte first. The trailer holds the time sampled on the packet's start beat, with seconds in bits 63:32 and nanoseconds in bits 31:0. `out_last` moves to the final trailer byte.
- R9: Every input beat appears on the output one cycle later. In append mode, `out_len` at the start beat equals `in_len`+8. Otherwise the packet, its length and its end marker pass unchanged.
- R10: While append mode is active, the receive register channel does not capture.
- R11: Whether a packet receives a trailer is decided on its start beat. A mode change in the middle of a packet does not affect that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_filter | input | 3 | Receive class select |
| cfg_append_en | input | 1 | Request trailer mode |
| cfg_ethertype | input | 16 | EtherType for layer-2 event frames |
| time_i | input | 64 | Current system time {seconds, nanoseconds} |
| rx_sof | input | 1 | Receive frame-start strobe |
| rx_is_v1 | input | 1 | Frame carries a version-1 message |
| rx_ethertype | input | 16 | Frame EtherType |
| rx_msg_code | input | 4 | Message code of the frame |
| tx_sof | input | 1 | Transmit frame-start strobe |
| tx_ts_req | input | 1 | Transmit frame wants a stamp |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| sw_clr | input | 2 | Per-channel release strobes |
| rd_data | output | 32 | Registered read data |
| rx_ts_valid | output | 1 | Receive channel holds a stamp |
| tx_ts_valid | output | 1 | Transmit channel holds a stamp |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of packet |
| in_last | input | 1 | Last byte of packet |
| in_len | input | 16 | Packet length, meaningful on the start beat |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output byte of packet |
| out_last | output | 1 | Last output byte of packet |
| out_len | output | 16 | Output packet length on the start beat |

## Verification
A lock flag stuck in the wrong state shows on the status word at the next read. It shows either as a missed capture or as a value overwritten by a later frame, which is exposed when the low and high words disagree with the time driven at the first frame. A wrong trailer index or a wrong byte order corrupts the eight bytes right after the payload, within nine cycles of the last input beat. A lost per-packet mode flag shows as a missing or misplaced end marker on that same packet. A full sweep over filter mode, version flag, message code and EtherType hit catches any misdecoded class on the first frame of that class.

// File: rtl/ts_capture_pkg.sv
package ts_capture_pkg;
  typedef enum logic [2:0] {
    FLT_OFF       = 3'd0,
    FLT_V1_SYNC   = 3'd1,
    FLT_V1_DLYREQ = 3'd2,
    FLT_V2_EVENT  = 3'd3,
    FLT_ANY       = 3'd4
  } flt_mode_e;

  localparam int unsigned CH_RX = 0;
  localparam int unsigned CH_TX = 1;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/ts_class_filter.sv
module ts_class_filter
  import ts_capture_pkg::*;
#(
  parameter int unsigned ET_W   = 16,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned EVT_CODES = 4
) (
  input  logic [2:0]        mode_i,
  input  logic [ET_W-1:0]   cfg_et_i,
  input  logic              is_v1_i,
  input  logic [ET_W-1:0]   et_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              match_o
);
  localparam logic [CODE_W-1:0] CODE_SYNC = CODE_W'(0);
  localparam logic [CODE_W-1:0] CODE_DREQ = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_EVT_LIM = CODE_W'(EVT_CODES);

  logic et_hit;
  logic evt_code;

  assign et_hit   = (et_i == cfg_et_i);
  assign evt_code = (code_i < CODE_EVT_LIM);

  always_comb begin
    match_o = 1'b0;
    case (flt_mode_e'(mode_i))
      FLT_V1_SYNC:   match_o = is_v1_i && (code_i == CODE_SYNC);
      FLT_V1_DLYREQ: match_o = is_v1_i && (code_i == CODE_DREQ);
      FLT_V2_EVENT:  match_o = et_hit && evt_code;
      FLT_ANY:       match_o = 1'b1;
      default:       match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ts_stamp_latch.sv
module ts_stamp_latch #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_req,
  input  logic              release_req,
  input  logic [TIME_W-1:0] time_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] stamp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      stamp_o <= '0;
    end else if (valid_o) begin
      if (release_req) valid_o <= 1'b0;
    end else if (cap_req) begin
      valid_o <= 1'b1;
      stamp_o <= time_i;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (cap_req && !valid_o) |=> (valid_o && stamp_o == $past(time_i)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !release_req) |=> (valid_o && $stable(stamp_o)));

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && release_req) |=> !valid_o);
endmodule

// File: rtl/ts_trailer_append.sv
module ts_trailer_append #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              append_active,
  input  logic [TIME_W-1:0] time_i,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_last,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_last,
  output logic [LEN_W-1:0]  out_len
);
  localparam int unsigned TRL_BYTES = TIME_W / 8;
  localparam int unsigned IDX_W = $clog2(TRL_BYTES);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(TRL_BYTES - 1);
  localparam logic [LEN_W-1:0] LEN_ADD = LEN_W'(TRL_BYTES);

  logic              pkt_app_q;
  logic [TIME_W-1:0] hold_q;
  logic              trl_busy;
  logic [IDX_W-1:0]  trl_idx;
  logic              beat_app;

  assign beat_app = in_sop ? append_active : pkt_app_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_last  <= 1'b0;
      out_len   <= '0;
      pkt_app_q <= 1'b0;
      hold_q    <= '0;
      trl_busy  <= 1'b0;
      trl_idx   <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_last  <= 1'b0;
      if (trl_busy) begin
        out_valid <= 1'b1;
        out_data  <= hold_q[trl_idx*8 +: 8];
        out_last  <= (trl_idx == IDX_END);
        trl_idx   <= trl_idx + 1'b1;
        if (trl_idx == IDX_END) trl_busy <= 1'b0;
      end else if (in_valid) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_sop   <= in_sop;
        out_last  <= in_last && !beat_app;
        out_len   <= (in_sop && append_active) ? in_len + LEN_ADD : in_len;
        if (in_sop) begin
          pkt_app_q <= append_active;
          hold_q    <= time_i;
        end
        if (in_last && beat_app) begin
          trl_busy <= 1'b1;
          trl_idx  <= '0;
        end
      end
    end
  end

  assert_gap_R8: assert property (@(posedge clk) disable iff (rst)
    trl_busy |-> !in_valid);

  assert_trailer_end_R8: assert property (@(posedge clk) disable iff (rst)
    (trl_busy && trl_idx == IDX_END) |=> (out_valid && out_last && !trl_busy));

  assert_no_early_last_R8: assert property (@(posedge clk) disable iff (rst)
    (trl_busy && trl_idx != IDX_END) |=> (out_valid && !out_last));
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_capture_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned ET_W   = 16,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_filter,
  input  logic              cfg_append_en,
  input  logic [ET_W-1:0]   cfg_ethertype,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rx_sof,
  input  logic              rx_is_v1,
  input  logic [ET_W-1:0]   rx_ethertype,
  input  logic [CODE_W-1:0] rx_msg_code,
  input  logic              tx_sof,
  input  logic              tx_ts_req,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        sw_clr,
  output logic [TIME_W/2-1:0] rd_data,
  output logic              rx_ts_valid,
  output logic              tx_ts_valid,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_last,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_last,
  output logic [LEN_W-1:0]  out_len
);
  localparam int unsigned HALF = TIME_W / 2;
  localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(2 * NUM_CH);

  logic              rx_match;
  logic              append_active;
  logic [NUM_CH-1:0] cap_w;
  logic [NUM_CH-1:0] rel_w;
  logic [NUM_CH-1:0] valid_w;
  logic [TIME_W-1:0] stamp_w [NUM_CH];
  logic [HALF-1:0]   rd_next;

  assign append_active = cfg_append_en && (cfg_filter != 3'(FLT_OFF));

  ts_class_filter #(.ET_W(ET_W), .CODE_W(CODE_W), .EVT_CODES(4)) u_filter (
    .mode_i   (cfg_filter),
    .cfg_et_i (cfg_ethertype),
    .is_v1_i  (rx_is_v1),
    .et_i     (rx_ethertype),
    .code_i   (rx_msg_code),
    .match_o  (rx_match)
  );

  assign cap_w[CH_RX] = rx_sof && rx_match && !append_active;
  assign cap_w[CH_TX] = tx_sof && tx_ts_req;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(2 * c + 2);
    assign rel_w[c] = sw_clr[c] || (rd_en && rd_addr == ADDR_HI);

    ts_stamp_latch #(.TIME_W(TIME_W)) u_latch (
      .clk         (clk),
      .rst         (rst),
      .cap_req     (cap_w[c]),
      .release_req (rel_w[c]),
      .time_i      (time_i),
      .valid_o     (valid_w[c]),
      .stamp_o     (stamp_w[c])
    );
  end

  assign rx_ts_valid = valid_w[CH_RX];
  assign tx_ts_valid = valid_w[CH_TX];

  always_comb begin
    rd_next = '0;
    if (rd_addr == '0) rd_next = HALF'(valid_w);
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(2 * c + 1)) rd_next = stamp_w[c][HALF-1:0];
      if (rd_addr == ADDR_W'(2 * c + 2)) rd_next = stamp_w[c][TIME_W-1:HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  ts_trailer_append #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_append (
    .clk           (clk),
    .rst           (rst),
    .append_active (append_active),
    .time_i        (time_i),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_sop        (in_sop),
    .in_last       (in_last),
    .in_len        (in_len),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_sop       (out_sop),
    .out_last      (out_last),
    .out_len       (out_len)
  );

  assert_map_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr > ADDR_TOP) |=> (rd_data == '0));

  assert_off_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_sof && cfg_filter == 3'(FLT_OFF) && !rx_ts_valid) |=> !rx_ts_valid);

  assert_append_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (append_active && !rx_ts_valid) |=> !rx_ts_valid);

  assert_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_clr[CH_TX] && tx_ts_valid) |=> !tx_ts_valid);
endmodule

// File: tb/ts_capture_latch_test.sv
module ts_capture_latch_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cfg_filter;
  logic        cfg_append_en;
  logic [15:0] cfg_ethertype;
  logic [63:0] time_i;
  logic        rx_sof, rx_is_v1;
  logic [15:0] rx_ethertype;
  logic [3:0]  rx_msg_code;
  logic        tx_sof, tx_ts_req;
  logic        rd_en;
  logic [2:0]  rd_addr;
  logic [1:0]  sw_clr;
  logic [31:0] rd_data;
  logic        rx_ts_valid, tx_ts_valid;
  logic        in_valid, in_sop, in_last;
  logic [7:0]  in_data;
  logic [15:0] in_len;
  logic        out_valid, out_sop, out_last;
  logic [7:0]  out_data;
  logic [15:0] out_len;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [15:0] ET = 16'h88F7;

  ts_capture_latch uut (
    .clk(clk), .rst(rst), .cfg_filter(cfg_filter), .cfg_append_en(cfg_append_en),
    .cfg_ethertype(cfg_ethertype), .time_i(time_i), .rx_sof(rx_sof),
    .rx_is_v1(rx_is_v1), .rx_ethertype(rx_ethertype), .rx_msg_code(rx_msg_code),
    .tx_sof(tx_sof), .tx_ts_req(tx_ts_req), .rd_en(rd_en), .rd_addr(rd_addr),
    .sw_clr(sw_clr), .rd_data(rd_data), .rx_ts_valid(rx_ts_valid),
    .tx_ts_valid(tx_ts_valid), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_last(in_last), .in_len(in_len), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_last(out_last), .out_len(out_len)
  );

  always #10 clk = ~clk;

  // output monitor
  logic [7:0]  cap_data [0:63];
  logic        cap_sop  [0:63];
  logic        cap_last [0:63];
  logic [15:0] cap_len;
  int          cap_n = 0;
  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin
      cap_data[cap_n] = out_data;
      cap_sop[cap_n]  = out_sop;
      cap_last[cap_n] = out_last;
      if (out_sop) cap_len = out_len;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic rx_frame(input logic v1, input logic [15:0] et, input logic [3:0] code,
                          input logic [63:0] t);
    @(negedge clk);
    rx_sof = 1'b1; rx_is_v1 = v1; rx_ethertype = et; rx_msg_code = code; time_i = t;
    @(negedge clk);
    rx_sof = 1'b0; time_i = ~t;
  endtask

  task automatic tx_frame(input logic req, input logic [63:0] t);
    @(negedge clk); tx_sof = 1'b1; tx_ts_req = req; time_i = t;
    @(negedge clk); tx_sof = 1'b0; tx_ts_req = 1'b0; time_i = ~t;
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); sw_clr = m;
    @(negedge clk); sw_clr = 2'b00;
  endtask

  // send a packet; flip_at>=0 toggles cfg_append_en on that beat
  task automatic send_pkt(input int len, input logic [7:0] seed, input logic [63:0] t,
                          input int flip_at, input logic exp_app, input string req);
    logic [63:0] tt;
    cap_n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == flip_at) cfg_append_en = ~cfg_append_en;
      in_valid = 1'b1; in_data = 8'(i * 7) + seed;
      in_sop = (i == 0); in_last = (i == len - 1); in_len = 16'(len);
      time_i = (i == 0) ? t : ~t;
    end
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0;
    repeat (11) @(negedge clk);
    tt = t;
    chk({req, " beats"}, 64'(cap_n), 64'(len + (exp_app ? 8 : 0)));
    chk({req, " len"}, 64'(cap_len), 64'(len + (exp_app ? 8 : 0)));
    for (int i = 0; i < len; i++)
      chk({req, " payload"}, 64'(cap_data[i]), 64'(8'(i * 7) + seed));
    if (exp_app)
      for (int k = 0; k < 8; k++)
        chk({req, " trailer byte"}, 64'(cap_data[len + k]), 64'(tt[k*8 +: 8]));
    for (int i = 0; i < cap_n; i++) begin
      chk({req, " sop flag"}, 64'(cap_sop[i]), 64'(i == 0));
      chk({req, " last flag"}, 64'(cap_last[i]), 64'(i == cap_n - 1));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    rst = 1'b1; cfg_filter = 3'd0; cfg_append_en = 1'b0; cfg_ethertype = ET;
    time_i = '0; rx_sof = 0; rx_is_v1 = 0; rx_ethertype = '0; rx_msg_code = '0;
    tx_sof = 0; tx_ts_req = 0; rd_en = 0; rd_addr = '0; sw_clr = '0;
    in_valid = 0; in_data = '0; in_sop = 0; in_last = 0; in_len = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state (R7 status word)
    rd(3'd0, d); chk("R7 reset status", 64'(d), 64'h0);
    chk("R9 reset out_valid", 64'(out_valid), 64'h0);

    // R1/R2/R4: sweep filter mode x version x code x ethertype hit
    for (int m = 0; m < 8; m++)
      for (int v = 0; v < 2; v++)
        for (int c = 0; c < 16; c++)
          for (int e = 0; e < 2; e++) begin
            logic pred;
            @(negedge clk); cfg_filter = 3'(m);
            pred = (m == 1 && v == 1 && c == 0) || (m == 2 && v == 1 && c == 1) ||
                   (m == 3 && e == 1 && c < 4) || (m == 4);
            t = {32'(m * 1000 + v * 100 + c * 2 + e), 32'h1000_0000 + 32'(c * 97 + e)};
            rx_frame(1'(v), e ? ET : 16'h0800, 4'(c), t);
            rd(3'd0, d); chk("R1 class match", 64'(d), 64'(pred));
            if (pred) begin
              rd(3'd1, d); chk("R2 captured low", 64'(d), 64'(t[31:0]));
              rd(3'd0, d); chk("R4 low read keeps lock", 64'(d), 64'h1);
              rd(3'd2, d); chk("R4 high word", 64'(d), 64'(t[63:32]));
              rd(3'd0, d); chk("R4 high read releases", 64'(d), 64'h0);
            end
          end

    // R3: hold while valid
    cfg_filter = 3'd4;
    rx_frame(0, 16'h0, 4'h0, 64'hAAAA_0001_BBBB_0001);
    rx_frame(0, 16'h0, 4'h0, 64'hCCCC_0002_DDDD_0002);
    rd(3'd1, d); chk("R3 low kept", 64'(d), 64'hBBBB_0001);
    rd(3'd2, d); chk("R3 high kept", 64'(d), 64'hAAAA_0001);
    rx_frame(0, 16'h0, 4'h0, 64'h1234_0003_5678_0003);
    rd(3'd1, d); chk("R4 recapture after release", 64'(d), 64'h5678_0003);

    // R6: transmit channel
    tx_frame(1'b0, 64'h0);
    rd(3'd0, d); chk("R6 no req no capture", 64'(d), 64'h1);
    tx_frame(1'b1, 64'h0BAD_F00D_0000_7777);
    rd(3'd0, d); chk("R6 tx valid", 64'(d), 64'h3);
    rd(3'd3, d); chk("R6 tx low", 64'(d), 64'h0000_7777);
    rd(3'd4, d); chk("R6 tx high", 64'(d), 64'h0BAD_F00D);
    rd(3'd0, d); chk("R4 tx high releases only tx", 64'(d), 64'h1);

    // R5: clear strobes per channel
    tx_frame(1'b1, 64'h5);
    clr(2'b01);
    rd(3'd0, d); chk("R5 rx clear only", 64'(d), 64'h2);
    clr(2'b10);
    rd(3'd0, d); chk("R5 tx clear", 64'(d), 64'h0);

    // R7: unused addresses
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R7 unused address", 64'(d), 64'h0);
    end

    // R8/R9: append mode, various lengths
    cfg_filter = 3'd4; cfg_append_en = 1'b1;
    for (int len = 1; len <= 6; len++)
      send_pkt(len, 8'(len * 16), {32'(len), 32'h3B9A_C9FF - 32'(len)}, -1, 1'b1, "R8 append");
    cfg_filter = 3'd3;
    send_pkt(5, 8'h40, 64'h0102_0304_0506_0708, -1, 1'b1, "R8 append filter 3");

    // R10: no register capture in append mode
    rx_frame(0, ET, 4'h0, 64'h99);
    rd(3'd0, d); chk("R10 register capture blocked", 64'(d), 64'h0);

    // R9: passthrough cases
    cfg_filter = 3'd0; cfg_append_en = 1'b1;
    send_pkt(4, 8'h11, 64'h7, -1, 1'b0, "R9 filter off passthrough");
    cfg_filter = 3'd4; cfg_append_en = 1'b0;
    send_pkt(3, 8'h22, 64'h8, -1, 1'b0, "R9 append disabled passthrough");

    // R11: decision latched at the start beat
    cfg_append_en = 1'b1;
    send_pkt(5, 8'h33, 64'hFEDC_BA98_7654_3210, 2, 1'b1, "R11 mid-packet disable");
    send_pkt(5, 8'h44, 64'h1, 2, 1'b0, "R11 mid-packet enable");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule